// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the operating power state of a small microcontroller and drives the enables that realise it. The block is always in one of four states. In `PM_NORMAL` the core and the peripherals run. In `PM_IDLE` the core is halted while peripherals keep their clocks. In `PM_SUSPEND` the core, the digital peripherals and the internal oscillators are all stopped. In `PM_SLEEP` most power domains are also switched off, and pins, RAM and registers keep their contents. Firmware asks for a state with one-cycle write strobes that set the matching mode-control bit.

The block returns to `PM_NORMAL` when a wake source permitted in the current state fires. Execution then continues from where it stopped. Each low-power state has its own set of permitted wake sources. The asynchronous wake inputs pass through a two-flop synchronizer. The comparator input is an edge source: only its synchronized rising edge counts. The other wake inputs are level sources.

Suspend is only legal while the system clock runs from one of the two fast internal oscillators. A suspend request made under any other clock source is dropped and raises a sticky error flag. A wake event that is already present when an entry request arrives cancels that entry. When the block leaves a low-power state, the mode-control bits clear themselves and a status field records the cause of the exit.

The transitions are:
- enter-idle: `PM_NORMAL`→`PM_IDLE`
- enter-suspend: `PM_NORMAL`→`PM_SUSPEND`
- enter-sleep: `PM_NORMAL`→`PM_SLEEP`
- wake-idle: `PM_IDLE`→`PM_NORMAL`
- wake-suspend: `PM_SUSPEND`→`PM_NORMAL`
- wake-sleep: `PM_SLEEP`→`PM_NORMAL`
- stay, in every state, when no qualifying strobe or wake event is present.

Top module: `pms_sequencer`

## Requirements
- R1: After reset the block is in `PM_NORMAL`. The outputs then read as follows:
  - `core_clk_en`=1, `osc_en`=1 and `pwr_down`=0.
  - `periph_clk_en` equals `periph_used`.
  - `mode_bits`=0, `wake_cause`=0 and `susp_err`=0.
- R2: A `set_idle` strobe in `PM_NORMAL` enters `PM_IDLE` at the next clock edge. In `PM_IDLE`:
  - `core_clk_en`=0 and `osc_en`=1.
  - `periph_clk_en` follows `periph_used` bit for bit.
  - `mode_bits` is 3'b001 (bit 0 is idle, bit 1 is suspend, bit 2 is sleep).
- R3: In `PM_IDLE`, `irq_pending` returns the block to `PM_NORMAL` at the next edge. The exit clears `mode_bits` to 0 and sets `wake_cause` to 1. No other input wakes `PM_IDLE`.
- R4: A `set_suspend` strobe with `sysclk_src` equal to 0 (low-power oscillator) or 1 (high-frequency oscillator) enters `PM_SUSPEND` at the next edge. In `PM_SUSPEND`, `core_clk_en`, `osc_en`, `periph_clk_en` and `pwr_down` are all 0, and `mode_bits`=3'b010.
- R5: A `set_suspend` strobe with `sysclk_src` equal to 2 (external) or 3 (low-frequency) is ignored: the block stays in `PM_NORMAL` with `mode_bits`=0. It sets `susp_err` to 1, and `susp_err` then stays 1 until reset.
- R6: The wake inputs are indexed as follows:
  - bit 0: RTC alarm, cause 2
  - bit 1: RTC fail, cause 3
  - bit 2: touch interrupt, cause 4
  - bit 3: port match, cause 5
  - bit 4: comparator, cause 6

  In `PM_SUSPEND` any of the five wakes the block. A change on `wake_in` that is set up before clock edge 1 gives `PM_NORMAL` after edge 3, and the block is still suspended after edge 2. `irq_pending` does not wake `PM_SUSPEND` or `PM_SLEEP`.
- R7: A `set_sleep` strobe enters `PM_SLEEP` at the next edge. In `PM_SLEEP`:
  - `pwr_down`=1.
  - `core_clk_en`, `osc_en` and `periph_clk_en` are all 0.
  - `mode_bits`=3'b100.

  The touch input (bit 2) never wakes `PM_SLEEP`. The other four wake sources do, with the same latency as in R6.
- R8: The comparator (bit 4) wakes the block only on a synchronized 0→1 transition. A level that is already high on entry does not wake the block.
- R9: An entry strobe that arrives while a wake event permitted in the target state is already active is cancelled, and the block stays in `PM_NORMAL` with `mode_bits`=0. For idle entry that event is `irq_pending`. For suspend or sleep entry it is a synchronized wake event.
- R10: When several strobes arrive together, sleep beats suspend and suspend beats idle. Strobes are ignored outside `PM_NORMAL`. At most one `mode_bits` bit is ever set.
- R11: When several wake sources fire in the same cycle, `wake_cause` reports the lowest-indexed of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| set_idle | input | 1 | Strobe: request Idle |
| set_suspend | input | 1 | Strobe: request Suspend |
| set_sleep | input | 1 | Strobe: request Sleep |
| sysclk_src | input | 2 | System clock source: 0 low-power osc, 1 high-frequency osc, 2 external, 3 low-frequency |
| irq_pending | input | 1 | Any enabled interrupt pending (synchronous) |
| wake_in | input | 5 | Asynchronous wake sources (see R6 for the bit order) |
| periph_used | input | NPERIPH | Which peripherals are in use |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| osc_en | output | 1 | Internal oscillator enable |
| pwr_down | output | 1 | Power-domain shutdown |
| mode_bits | output | 3 | Mode-control bits {sleep, suspend, idle} |
| wake_cause | output | 3 | Cause of the last exit (0 none, 1 interrupt, 2 to 6 wake bit 0 to 4) |
| susp_err | output | 1 | Sticky illegal-clock suspend error |

## Verification
Results fall due at three different latencies:
- Strobes and `irq_pending` act at the next clock edge, so the bench drives them on a falling edge and checks on the following falling edge.
- Asynchronous wake inputs need three edges: two synchronizer flops, then the state register. The bench checks both after the second edge, when the block must still be low-power, and after the third, when it must be back in `PM_NORMAL`.
- After a wake input falls, the synchronized level stays high for two more edges. The bench therefore waits at least four cycles before a new entry, so that no entry is cancelled by accident.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'd0,
        PM_IDLE    = 2'd1,
        PM_SUSPEND = 2'd2,
        PM_SLEEP   = 2'd3
    } pm_state_t;

    localparam int WK_NUM   = 5;
    localparam int WK_ALARM = 0;
    localparam int WK_FAIL  = 1;
    localparam int WK_TOUCH = 2;
    localparam int WK_MATCH = 3;
    localparam int WK_CMP   = 4;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_IRQ   = 3'd1,
        CAUSE_ALARM = 3'd2,
        CAUSE_FAIL  = 3'd3,
        CAUSE_TOUCH = 3'd4,
        CAUSE_MATCH = 3'd5,
        CAUSE_CMP   = 3'd6
    } wake_cause_t;

    localparam logic [1:0] SRC_LPOSC = 2'd0;
    localparam logic [1:0] SRC_HFOSC = 2'd1;
    localparam logic [1:0] SRC_EXT   = 2'd2;
    localparam logic [1:0] SRC_LFOSC = 2'd3;

    // Wake sources accepted in each deep state
    localparam logic [WK_NUM-1:0] MASK_SUSPEND = 5'b11111;
    localparam logic [WK_NUM-1:0] MASK_SLEEP   = 5'b11011;

endpackage

// File: rtl/pms_wake_sync.sv
module pms_wake_sync #(
    parameter int N           = 5,
    parameter int EDGE_IDX    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][N-1:0] chain_q;
    logic                          edge_prev_q;
    logic [N-1:0]                  synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q     <= '0;
            edge_prev_q <= 1'b0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
            edge_prev_q <= chain_q[LAST][EDGE_IDX];
        end
    end

    assign synced = chain_q[LAST];

    for (genvar b = 0; b < N; b++) begin : g_evt
        if (b == EDGE_IDX) begin : g_edge
            assign evt[b] = synced[b] & ~edge_prev_q;
        end else begin : g_level
            assign evt[b] = synced[b];
        end
    end

endmodule

// File: rtl/pms_wake_qual.sv
module pms_wake_qual
    import pms_pkg::*;
(
    input  pm_state_t           mode,
    input  logic                irq,
    input  logic [WK_NUM-1:0]   evt,
    output logic                hit,
    output wake_cause_t         cause
);
    logic [WK_NUM-1:0] masked;

    always_comb begin
        hit    = 1'b0;
        cause  = CAUSE_NONE;
        masked = '0;
        case (mode)
            PM_IDLE: begin
                if (irq) begin
                    hit   = 1'b1;
                    cause = CAUSE_IRQ;
                end
            end
            PM_SUSPEND, PM_SLEEP: begin
                masked = evt & ((mode == PM_SLEEP) ? MASK_SLEEP : MASK_SUSPEND);
                // Descending scan: lowest index is written last and wins
                for (int i = WK_NUM - 1; i >= 0; i--) begin
                    if (masked[i]) begin
                        hit   = 1'b1;
                        cause = wake_cause_t'(3'(i + 2));
                    end
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pms_entry_arb.sv
module pms_entry_arb
    import pms_pkg::*;
(
    input  logic       set_idle,
    input  logic       set_suspend,
    input  logic       set_sleep,
    input  logic [1:0] sysclk_src,
    output pm_state_t  target,
    output logic       clk_bad
);
    logic src_ok;

    assign src_ok = (sysclk_src == SRC_LPOSC) || (sysclk_src == SRC_HFOSC);

    always_comb begin
        target  = PM_NORMAL;
        clk_bad = 1'b0;
        if (set_sleep) begin
            target = PM_SLEEP;
        end else if (set_suspend) begin
            if (src_ok) begin
                target = PM_SUSPEND;
            end else begin
                clk_bad = 1'b1;
            end
        end else if (set_idle) begin
            target = PM_IDLE;
        end
    end

endmodule

// File: rtl/pms_sequencer.sv
module pms_sequencer
    import pms_pkg::*;
#(
    parameter int NPERIPH     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_idle,
    input  logic               set_suspend,
    input  logic               set_sleep,
    input  logic [1:0]         sysclk_src,
    input  logic               irq_pending,
    input  logic [4:0]         wake_in,
    input  logic [NPERIPH-1:0] periph_used,
    output logic               core_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               osc_en,
    output logic               pwr_down,
    output logic [2:0]         mode_bits,
    output logic [2:0]         wake_cause,
    output logic               susp_err
);
    pm_state_t   state_q, state_d;
    pm_state_t   req_target;
    logic        req_clk_bad;
    logic [WK_NUM-1:0] wk_evt;
    logic        exit_hit, cancel_hit;
    wake_cause_t exit_cause, cancel_cause_unused;
    logic [2:0]  ctrl_q;
    wake_cause_t cause_q;
    logic        err_q;

    pms_wake_sync #(
        .N(WK_NUM), .EDGE_IDX(WK_CMP), .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(wake_in), .evt(wk_evt)
    );

    pms_entry_arb u_arb (
        .set_idle(set_idle), .set_suspend(set_suspend), .set_sleep(set_sleep),
        .sysclk_src(sysclk_src), .target(req_target), .clk_bad(req_clk_bad)
    );

    // Exit qualification against the present state
    pms_wake_qual u_exit (
        .mode(state_q), .irq(irq_pending), .evt(wk_evt),
        .hit(exit_hit), .cause(exit_cause)
    );

    // Cancel qualification against the requested state
    pms_wake_qual u_cancel (
        .mode(req_target), .irq(irq_pending), .evt(wk_evt),
        .hit(cancel_hit), .cause(cancel_cause_unused)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_NORMAL: begin
                if ((req_target != PM_NORMAL) && !cancel_hit) begin
                    state_d = req_target;
                end
            end
            PM_IDLE, PM_SUSPEND, PM_SLEEP: begin
                if (exit_hit) begin
                    state_d = PM_NORMAL;
                end
            end
        endcase
    end

    // State register and mode bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_NORMAL;
            ctrl_q  <= '0;
            cause_q <= CAUSE_NONE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == PM_NORMAL) begin
                if (req_clk_bad) begin
                    err_q <= 1'b1;
                end
                unique case (state_d)
                    PM_IDLE:    ctrl_q <= 3'b001;
                    PM_SUSPEND: ctrl_q <= 3'b010;
                    PM_SLEEP:   ctrl_q <= 3'b100;
                    PM_NORMAL:  ctrl_q <= 3'b000;
                endcase
            end else if (state_d == PM_NORMAL) begin
                ctrl_q  <= 3'b000;
                cause_q <= exit_cause;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            PM_NORMAL: begin
                core_clk_en   = 1'b1;
                periph_clk_en = periph_used;
                osc_en        = 1'b1;
                pwr_down      = 1'b0;
            end
            PM_IDLE: begin
                core_clk_en   = 1'b0;
                periph_clk_en = periph_used;
                osc_en        = 1'b1;
                pwr_down      = 1'b0;
            end
            PM_SUSPEND: begin
                core_clk_en   = 1'b0;
                periph_clk_en = '0;
                osc_en        = 1'b0;
                pwr_down      = 1'b0;
            end
            PM_SLEEP: begin
                core_clk_en   = 1'b0;
                periph_clk_en = '0;
                osc_en        = 1'b0;
                pwr_down      = 1'b1;
            end
        endcase
    end

    assign mode_bits  = ctrl_q;
    assign wake_cause = cause_q;
    assign susp_err   = err_q;

    // ---------------- Assertions ----------------
    assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_IDLE && irq_pending) |=> (state_q == PM_NORMAL));

    assert_bits_clear_on_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PM_NORMAL) ##1 (state_q == PM_NORMAL) |-> (mode_bits == 3'b000));

    assert_bad_src_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_NORMAL && set_suspend && !set_sleep &&
         (sysclk_src == SRC_EXT || sysclk_src == SRC_LFOSC))
        |=> (state_q == PM_NORMAL && susp_err));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        susp_err |=> susp_err);

    assert_touch_no_sleep_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SLEEP && !wk_evt[WK_ALARM] && !wk_evt[WK_FAIL] &&
         !wk_evt[WK_MATCH] && !wk_evt[WK_CMP]) |=> (state_q == PM_SLEEP));

    assert_cancel_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_NORMAL && cancel_hit) |=> (state_q == PM_NORMAL));

    assert_onehot_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_bits));

    assert_suspend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SUSPEND && !exit_hit) |=> (state_q == PM_SUSPEND));

endmodule

// File: tb/pms_sequencer_tb.sv
module pms_sequencer_tb_top;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          set_idle = 0, set_suspend = 0, set_sleep = 0;
    logic [1:0]    sysclk_src = 2'd0;
    logic          irq_pending = 0;
    logic [4:0]    wake_in = '0;
    logic [NP-1:0] periph_used = 4'b1010;
    logic          core_clk_en, osc_en, pwr_down, susp_err;
    logic [NP-1:0] periph_clk_en;
    logic [2:0]    mode_bits, wake_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    pms_sequencer #(.NPERIPH(NP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .set_idle(set_idle), .set_suspend(set_suspend), .set_sleep(set_sleep),
        .sysclk_src(sysclk_src), .irq_pending(irq_pending), .wake_in(wake_in),
        .periph_used(periph_used),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .pwr_down(pwr_down), .mode_bits(mode_bits), .wake_cause(wake_cause),
        .susp_err(susp_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // outputs packed {core, osc, pd, periph}
    function automatic logic [31:0] outs();
        return {25'd0, core_clk_en, osc_en, pwr_down, periph_clk_en};
    endfunction

    task automatic t_reset();
        chk("R1", "outputs", outs(), {25'd0, 1'b1, 1'b1, 1'b0, 4'b1010});
        chk("R1", "mode_bits", mode_bits, 0);
        chk("R1", "wake_cause", wake_cause, 0);
        chk("R1", "susp_err", susp_err, 0);
    endtask

    task automatic t_idle();
        set_idle = 1; cyc(1); set_idle = 0;
        chk("R2", "idle outputs", outs(), {25'd0, 1'b0, 1'b1, 1'b0, 4'b1010});
        chk("R2", "idle bits", mode_bits, 3'b001);
        periph_used = 4'b0110; cyc(1);
        chk("R2", "idle periph follows", periph_clk_en, 4'b0110);
        wake_in = 5'b00001; cyc(4);
        chk("R3", "idle ignores wake_in", core_clk_en, 0);
        wake_in = 0; cyc(3);
        irq_pending = 1; cyc(1); irq_pending = 0;
        chk("R3", "idle exit core", core_clk_en, 1);
        chk("R3", "idle exit bits", mode_bits, 0);
        chk("R3", "idle exit cause", wake_cause, 1);
        periph_used = 4'b1010;
    endtask

    task automatic t_suspend_wake(input int idx, input logic [1:0] src);
        sysclk_src = src;
        set_suspend = 1; cyc(1); set_suspend = 0;
        chk("R4", "suspend outputs", outs(), 0);
        chk("R4", "suspend bits", mode_bits, 3'b010);
        irq_pending = 1; cyc(2); irq_pending = 0;
        chk("R6", "irq ignored in suspend", core_clk_en, 0);
        wake_in[idx] = 1'b1; cyc(2);
        chk("R6", "still suspended after 2 edges", core_clk_en, 0);
        cyc(1);
        chk("R6", "woken after 3 edges", core_clk_en, 1);
        chk("R6", "cause", wake_cause, idx + 2);
        wake_in = 0; cyc(4);
    endtask

    task automatic t_bad_clk();
        sysclk_src = 2'd2;
        set_suspend = 1; cyc(1); set_suspend = 0;
        chk("R5", "ext src stays normal", core_clk_en, 1);
        chk("R5", "ext src bits", mode_bits, 0);
        chk("R5", "err set", susp_err, 1);
        sysclk_src = 2'd3;
        set_suspend = 1; cyc(1); set_suspend = 0;
        chk("R5", "lf src stays normal", osc_en, 1);
        sysclk_src = 2'd1;
    endtask

    task automatic t_sleep();
        set_sleep = 1; cyc(1); set_sleep = 0;
        chk("R7", "sleep outputs", outs(), {25'd0, 1'b0, 1'b0, 1'b1, 4'b0000});
        chk("R7", "sleep bits", mode_bits, 3'b100);
        wake_in[2] = 1; cyc(5);
        chk("R7", "touch ignored in sleep", pwr_down, 1);
        wake_in = 0; cyc(4);
        wake_in[3] = 1; cyc(3);
        chk("R7", "match wakes sleep", pwr_down, 0);
        chk("R7", "match cause", wake_cause, 5);
        wake_in = 0; cyc(4);
    endtask

    task automatic t_cmp_level();
        wake_in[4] = 1; cyc(4);
        set_suspend = 1; cyc(1); set_suspend = 0;
        chk("R8", "entered with cmp high", core_clk_en, 0);
        cyc(5);
        chk("R8", "cmp level no wake", core_clk_en, 0);
        wake_in[4] = 0; cyc(3);
        wake_in[4] = 1; cyc(3);
        chk("R8", "cmp rise wakes", core_clk_en, 1);
        chk("R8", "cmp cause", wake_cause, 6);
        wake_in = 0; cyc(4);
    endtask

    task automatic t_cancel();
        irq_pending = 1; set_idle = 1; cyc(1); irq_pending = 0; set_idle = 0;
        chk("R9", "idle cancelled", core_clk_en, 1);
        chk("R9", "idle cancel bits", mode_bits, 0);
        wake_in[0] = 1; cyc(2);
        set_suspend = 1; cyc(1); set_suspend = 0;
        chk("R9", "suspend cancelled", core_clk_en, 1);
        chk("R9", "suspend cancel bits", mode_bits, 0);
        wake_in = 0; cyc(4);
    endtask

    task automatic t_priority();
        set_idle = 1; set_sleep = 1; set_suspend = 1; cyc(1);
        set_idle = 0; set_sleep = 0; set_suspend = 0;
        chk("R10", "sleep wins", mode_bits, 3'b100);
        set_idle = 1; cyc(1); set_idle = 0;
        chk("R10", "strobe ignored in sleep", mode_bits, 3'b100);
        wake_in = 5'b01001; cyc(3);
        chk("R11", "alarm beats match", wake_cause, 2);
        wake_in = 0; cyc(4);
        set_suspend = 1; cyc(1); set_suspend = 0;
        wake_in = 5'b11000; cyc(3);
        chk("R11", "match beats cmp", wake_cause, 5);
        wake_in = 0; cyc(4);
        chk("R5", "err still sticky", susp_err, 1);
    endtask

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        t_reset();
        t_idle();
        for (int i = 0; i < 5; i++) t_suspend_wake(i, (i % 2 == 0) ? 2'd0 : 2'd1);
        t_bad_clk();
        t_sleep();
        t_cmp_level();
        t_cancel();
        t_priority();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule